// File: doc/BRIEF.md
# DDR Refresh Obligation Scheduler

This block sits on the controller side of a DDR SDRAM interface and decides when an auto-refresh command has to be sent. A free-running interval timer raises one refresh obligation per refresh period. The period is derived from the clock period, and the default values give a 15.6 us average, which is 4096 refreshes every 64 ms. Obligations accumulate in a bounded backlog, so refreshes can be postponed while the memory is busy. The backlog saturates at eight, which is the largest burst of back-to-back refreshes the device tolerates.

The block asks the command arbiter for a slot and waits for a grant. A refresh is only requested when the arbiter reports all banks closed. Once the backlog reaches a threshold, the request becomes urgent: new row activations are blocked, and a precharge-all request is raised while any bank is open. After every granted refresh, all commands are held off for the refresh row cycle time. A self-refresh request uses the same request and grant path. The entry command is flagged with a select signal, and the clock enable drops on grant. When the request is withdrawn the clock enable rises, and separate hold-off windows gate the first non-read and the first read command.

Top module: `rfs_sched`

## Requirements
- R1: One obligation is added to `owed` every REFI_CYC = REFI_PS/CLK_PS clock cycles. The timer free-runs from reset and does not restart when a refresh is issued, so the first obligation appears REFI_CYC cycles after reset release.
- R2: `owed` never exceeds OWE_MAX (8). An interval that ends while `owed` equals OWE_MAX and no refresh is granted leaves it at OWE_MAX.
- R3: `ref_req` is 1 only while running (`cke`=1), with `banks_closed`=1, `cmd_block`=0 and either `owed`>0 or `sr_req`=1. A cycle with `ref_req`=1 and `ref_gnt`=1 issues the command. A normal refresh lowers `owed` by one, and a grant while `ref_req`=0 changes nothing.
- R4: `ref_urgent` and `act_block` are 1 exactly when `owed` >= URG_LVL (4).
- R5: `pre_all_req` is 1 when the request is urgent and `banks_closed`=0. `ref_req` stays 0 while `banks_closed`=0.
- R6: After a granted normal refresh, `cmd_block` is 1 in the following RFC_CYC-1 cycles (RFC_CYC = RFC_PS/CLK_PS rounded up), so the next command can be granted RFC_CYC cycles after the refresh. `ref_req` is 0 throughout.
- R7: While `sr_req`=1, a request carries `ref_self`=1 (self-refresh entry). On its grant `cke` falls in the next cycle and `owed` clears. While `cke`=0, `owed` stays 0 and `ref_req` stays 0.
- R8: Lowering `sr_req` while `cke`=0 raises `cke` in the next cycle. `cmd_block` is then 1 for XSNR_CYC-1 cycles (XSNR_PS/CLK_PS rounded up), and `rd_block` is 1 for XSRD_CYC-1 cycles.
- R9: During reset `owed`=0, `cke`=1, and `ref_req`, `cmd_block` and `rd_block` are 0.
- R10: With grants always given and banks closed, exactly one refresh is issued per interval over a long window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| banks_closed | input | 1 | All banks are precharged |
| sr_req | input | 1 | Hold high to enter and stay in self-refresh |
| ref_gnt | input | 1 | Arbiter grants the requested refresh command |
| ref_req | output | 1 | Refresh (or self-refresh entry) command wanted |
| ref_self | output | 1 | Requested command is self-refresh entry (clock enable low) |
| ref_urgent | output | 1 | Backlog at or above the urgent threshold |
| pre_all_req | output | 1 | Urgent refresh waiting on open banks; precharge all |
| act_block | output | 1 | New row activations are forbidden |
| cmd_block | output | 1 | No command may be granted this cycle |
| rd_block | output | 1 | No read may be granted this cycle |
| cke | output | 1 | Clock enable to the device |
| owed | output | $clog2(OWE_MAX+1) | Number of postponed refreshes |

## Verification
A backlog counter that drifts shows at the `owed` port within one refresh interval. It also shows as a wrong issue count over a window of intervals, and as a wrong urgent or precharge-all flag once the count crosses four. A guard counter loaded with the wrong value shows as a `cmd_block` or `rd_block` window that is one or more cycles too short or too long, measured from the grant edge or the `cke` rise. A wrong state in the self-refresh sequencer shows at once as `cke` failing to fall on the entry grant, or as requests appearing while `cke` is low.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic {
    RS_RUN  = 1'b0,
    RS_SELF = 1'b1
  } rs_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rfs_tick.sv
module rfs_tick #(
  parameter int PERIOD = 2080
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    if (tick) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfs_backlog.sv
module rfs_backlog #(
  parameter int MAX = 8,
  parameter int W   = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  input  logic         clr,
  output logic [W-1:0] owed
);
  localparam logic [W-1:0] TOP = W'(MAX);

  logic [W-1:0] owed_q, owed_d;
  logic         owed_en;

  always_comb begin
    owed_d  = owed_q;
    owed_en = 1'b0;
    if (clr) begin
      owed_d  = '0;
      owed_en = 1'b1;
    end else if (inc && !dec) begin
      if (owed_q != TOP) begin
        owed_d  = owed_q + 1'b1;
        owed_en = 1'b1;
      end
    end else if (dec && !inc) begin
      if (owed_q != '0) begin
        owed_d  = owed_q - 1'b1;
        owed_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       owed_q <= '0;
    else if (owed_en) owed_q <= owed_d;
  end

  assign owed = owed_q;
endmodule

// File: rtl/rfs_guard.sv
module rfs_guard #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (busy) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfs_sched.sv
module rfs_sched
  import rfs_pkg::*;
#(
  parameter int CLK_PS   = 7500,
  parameter int REFI_PS  = 15600000,
  parameter int RFC_PS   = 75000,
  parameter int XSNR_PS  = 75000,
  parameter int XSRD_CYC = 200,
  parameter int OWE_MAX  = 8,
  parameter int URG_LVL  = 4,
  localparam int OW = $clog2(OWE_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          banks_closed,
  input  logic          sr_req,
  input  logic          ref_gnt,
  output logic          ref_req,
  output logic          ref_self,
  output logic          ref_urgent,
  output logic          pre_all_req,
  output logic          act_block,
  output logic          cmd_block,
  output logic          rd_block,
  output logic          cke,
  output logic [OW-1:0] owed
);
  localparam int REFI_CYC = REFI_PS / CLK_PS;
  localparam int RFC_CYC  = ceil_div(RFC_PS, CLK_PS);
  localparam int XSNR_CYC = ceil_div(XSNR_PS, CLK_PS);
  localparam int GW       = $clog2(max3(RFC_CYC, XSNR_CYC, XSRD_CYC) + 1);
  localparam int NGUARD   = 2;
  localparam logic [GW-1:0] RFC_LD  = GW'(RFC_CYC - 1);
  localparam logic [GW-1:0] XSNR_LD = GW'(XSNR_CYC - 1);
  localparam logic [GW-1:0] XSRD_LD = GW'(XSRD_CYC - 1);
  localparam logic [OW-1:0] URG_V   = OW'(URG_LVL);

  rs_state_e state_q, state_d;
  logic      tick, pending, ref_issue, norm_issue, self_enter, exit_evt;
  logic      owe_inc;
  logic [NGUARD-1:0] g_busy;
  logic              g_load [NGUARD];
  logic [GW-1:0]     g_val  [NGUARD];

  rfs_tick #(.PERIOD(REFI_CYC)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  rfs_backlog #(.MAX(OWE_MAX), .W(OW)) u_owe (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (owe_inc),
    .dec  (norm_issue),
    .clr  (self_enter),
    .owed (owed)
  );

  // guard 0: command hold-off, guard 1: read hold-off after self-refresh exit
  for (genvar g = 0; g < NGUARD; g++) begin : g_guard
    rfs_guard #(.W(GW)) u_guard (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (g_load[g]),
      .load_val(g_val[g]),
      .busy    (g_busy[g])
    );
  end

  assign cmd_block = g_busy[0];
  assign rd_block  = g_busy[0] | g_busy[1];

  assign pending    = (owed != '0);
  assign ref_req    = (state_q == RS_RUN) && banks_closed && !cmd_block
                      && (pending || sr_req);
  assign ref_self   = ref_req && sr_req;
  assign ref_issue  = ref_req && ref_gnt;
  assign self_enter = ref_issue && sr_req;
  assign norm_issue = ref_issue && !sr_req;
  assign exit_evt   = (state_q == RS_SELF) && !sr_req;
  assign owe_inc    = tick && (state_q == RS_RUN) && !self_enter;

  assign ref_urgent  = (owed >= URG_V);
  assign act_block   = ref_urgent;
  assign pre_all_req = ref_urgent && !banks_closed;
  assign cke         = (state_q != RS_SELF);

  always_comb begin
    g_load[0] = norm_issue || exit_evt;
    g_val[0]  = exit_evt ? XSNR_LD : RFC_LD;
    g_load[1] = exit_evt;
    g_val[1]  = XSRD_LD;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RS_RUN:  if (self_enter) state_d = RS_SELF;
      RS_SELF: if (exit_evt)   state_d = RS_RUN;
      default: state_d = RS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RS_RUN;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/rfs_sched_chk.sv
module rfs_sched_chk #(
  parameter int OWE_MAX = 8,
  localparam int OW = $clog2(OWE_MAX + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          banks_closed,
  input logic          ref_gnt,
  input logic          ref_req,
  input logic          ref_self,
  input logic          cmd_block,
  input logic          rd_block,
  input logic          cke,
  input logic [OW-1:0] owed
);
  // R2
  owe_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(owed) <= OWE_MAX);

  // R1
  owe_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(owed) <= int'($past(owed)) + 1);

  // R6
  rfc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt && !ref_self) |=> cmd_block);

  // R6
  blk_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_block |-> !ref_req);

  // R5
  open_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !banks_closed |-> !ref_req);

  // R7
  self_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt && ref_self) |=> !cke);

  // R7
  self_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (owed == '0 && !ref_req));

  // R8
  exit_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (cmd_block && rd_block));
endmodule

bind rfs_sched rfs_sched_chk #(.OWE_MAX(OWE_MAX)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .banks_closed(banks_closed),
  .ref_gnt     (ref_gnt),
  .ref_req     (ref_req),
  .ref_self    (ref_self),
  .cmd_block   (cmd_block),
  .rd_block    (rd_block),
  .cke         (cke),
  .owed        (owed)
);

// File: tb/sim_rfs_sched.sv
module sim_rfs_sched;
  localparam int CLK_PERIOD = 10;
  localparam int REFI_CYC   = 40;
  localparam int RFC_CYC    = 8;
  localparam int XSNR_CYC   = 8;
  localparam int XSRD_CYC   = 20;

  logic clk, rst_n, banks_closed, sr_req, ref_gnt;
  logic ref_req, ref_self, ref_urgent, pre_all_req, act_block;
  logic cmd_block, rd_block, cke;
  logic [3:0] owed;

  int checks = 0;
  int errors = 0;
  int cur    = 0;

  rfs_sched #(
    .CLK_PS  (10000),
    .REFI_PS (400000),
    .RFC_PS  (75000),
    .XSNR_PS (75000),
    .XSRD_CYC(XSRD_CYC),
    .OWE_MAX (8),
    .URG_LVL (4)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .banks_closed(banks_closed), .sr_req(sr_req),
    .ref_gnt(ref_gnt), .ref_req(ref_req), .ref_self(ref_self),
    .ref_urgent(ref_urgent), .pre_all_req(pre_all_req), .act_block(act_block),
    .cmd_block(cmd_block), .rd_block(rd_block), .cke(cke), .owed(owed)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    int   edge_no;
    logic bc;
    logic [3:0] exp_owed;
    logic exp_req;
    logic exp_urg;
    logic exp_pre;
  } vec_t;

  // walked with ref_gnt=0 and sr_req=0, edges counted from reset release
  localparam vec_t TBL [7] = '{
    '{ 39, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0},
    '{ 40, 1'b1, 4'd1, 1'b1, 1'b0, 1'b0},
    '{120, 1'b1, 4'd3, 1'b1, 1'b0, 1'b0},
    '{160, 1'b0, 4'd4, 1'b0, 1'b1, 1'b1},
    '{200, 1'b0, 4'd5, 1'b0, 1'b1, 1'b1},
    '{320, 1'b1, 4'd8, 1'b1, 1'b1, 1'b0},
    '{360, 1'b1, 4'd8, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cur++;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int nref, maxo, bad, cb, rb;
    rst_n = 1'b0; banks_closed = 1'b1; sr_req = 1'b0; ref_gnt = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 owed", int'(owed), 0);
    chk("R9 cke", int'(cke), 1);
    chk("R9 ref_req", int'(ref_req), 0);
    chk("R9 cmd_block", int'(cmd_block), 0);
    chk("R9 rd_block", int'(rd_block), 0);
    rst_n = 1'b1;
    cur = 0;

    // R1 R2 R4 R5 backlog growth table
    for (int i = 0; i < 7; i++) begin
      banks_closed = TBL[i].bc;
      while (cur < TBL[i].edge_no) step();
      chk("R1/R2 owed", int'(owed), int'(TBL[i].exp_owed));
      chk("R3/R5 ref_req", int'(ref_req), int'(TBL[i].exp_req));
      chk("R4 ref_urgent", int'(ref_urgent), int'(TBL[i].exp_urg));
      chk("R4 act_block", int'(act_block), int'(TBL[i].exp_urg));
      chk("R5 pre_all_req", int'(pre_all_req), int'(TBL[i].exp_pre));
    end

    // R3 grant while no request is ignored
    banks_closed = 1'b0; ref_gnt = 1'b1;
    repeat (3) step();
    chk("R3 grant ignored", int'(owed), 8);
    // R6 refresh issue and hold-off window
    banks_closed = 1'b1;
    step();
    ref_gnt = 1'b0;
    chk("R3 retire", int'(owed), 7);
    chk("R6 req low", int'(ref_req), 0);
    cb = 0;
    for (int k = 0; k < 30 && cmd_block; k++) begin
      cb++;
      if (ref_req) bad++;
      step();
    end
    chk("R6 rfc window", cb, RFC_CYC - 1);
    chk("R6 req back", int'(ref_req), 1);

    // R10 long-window rate
    do_reset();
    banks_closed = 1'b1; ref_gnt = 1'b1;
    nref = 0; maxo = 0; bad = 0;
    for (int k = 0; k < 50 * REFI_CYC; k++) begin
      step();
      if (ref_req && ref_gnt) nref++;
      if (int'(owed) > maxo) maxo = int'(owed);
      if (cmd_block && ref_req) bad++;
    end
    ref_gnt = 1'b0;
    chk("R10 refresh count", nref, 50);
    chk("R10 backlog peak", maxo, 1);
    chk("R6 req in window", bad, 0);

    // R7 self-refresh entry
    repeat (10) step();
    sr_req = 1'b1;
    #1;
    chk("R7 req", int'(ref_req), 1);
    chk("R7 ref_self", int'(ref_self), 1);
    ref_gnt = 1'b1;
    step();
    ref_gnt = 1'b0;
    chk("R7 cke low", int'(cke), 0);
    chk("R7 owed clr", int'(owed), 0);
    repeat (100) step();
    chk("R7 ticks ignored", int'(owed), 0);
    chk("R7 no req", int'(ref_req), 0);
    chk("R7 still self", int'(cke), 0);

    // R8 exit windows
    sr_req = 1'b0;
    step();
    chk("R8 cke high", int'(cke), 1);
    cb = 0; rb = 0;
    for (int k = 0; k < 40; k++) begin
      if (cmd_block) cb++;
      if (rd_block) rb++;
      step();
    end
    chk("R8 nonread window", cb, XSNR_CYC - 1);
    chk("R8 read window", rb, XSRD_CYC - 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule